// File: doc/BRIEF.md
# Bus Transceiver Mode and Dominant Time-out Controller

This block is the digital control core of a differential field-bus line transceiver. It works on an already-digitised bus indication and has two modes. In normal mode the transmit line drives the bus dominant while it is low. A dominant time-out releases the driver if the transmit line stays low too long, and only the next rising edge on the transmit line removes it. In the low-power standby mode the driver is always released. A digital run-length filter then passes only long dominant stretches on the bus to the receive output, so that a sleeping controller can be woken by bus activity.

The transmit, standby and bus inputs each pass through a two-flop synchroniser. All timing comes from one clock. The parameter `CYC_PER_US` sets how many clock cycles make one microsecond, and the time-out (`TMO_US`, in microseconds) and the wake threshold (`WAKE_CYC`, in cycles) follow from it. A high level on the transmit input or the standby input is the idle, recessive or standby state. A board pull-up therefore makes an open pin behave safely. After reset the block is in standby with the driver released.

Top module: `bxc_ctrl`

## Requirements
- R1: During and right after reset the driver is released (`drv_en_o`=0, `drv_dom_o`=0), `rxd_o` is 1 and `tmo_flag_o` is 0.
- R2: In normal mode (`stby_in`=0), once the driver is armed and with no time-out pending, a low `txd_in` gives `drv_en_o`=1 and `drv_dom_o`=1 two clock cycles later.
- R3: In normal mode with `txd_in` high, `drv_en_o`=1 and `drv_dom_o`=0, so the bus is recessive.
- R4: While `stby_in`=1, `drv_en_o` and `drv_dom_o` stay 0 whatever `txd_in` does.
- R5: After `stby_in` falls, the driver stays released until `txd_in` has been sampled high at least once in normal mode. A transmit line held low across the mode change never drives the bus.
- R6: A low stretch on `txd_in` drives the bus dominant for at most TMO_CYC = CYC_PER_US*TMO_US consecutive cycles. The driver is then released and `tmo_flag_o` rises.
- R7: `tmo_flag_o` stays 1, and the driver stays released, until a rising edge on the synchronised `txd_in`. The flag clears one cycle after that edge, and the next low stretch drives again.
- R8: In normal mode `rxd_o` equals the inverse of `bus_dom_in` (1 = dominant) delayed by two clock cycles.
- R9: In standby, a dominant stretch of P cycles with P < WAKE_CYC leaves `rxd_o` at 1. With P >= WAKE_CYC, `rxd_o` is 0 for exactly P-WAKE_CYC+1 cycles, starting WAKE_CYC+2 cycles after the stretch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| txd_in | input | 1 | Transmit data, 0 = dominant request |
| stby_in | input | 1 | Mode select, 1 = standby, 0 = normal |
| bus_dom_in | input | 1 | Digitised bus state, 1 = dominant |
| drv_en_o | output | 1 | Bus driver enabled |
| drv_dom_o | output | 1 | Driver pulls the bus dominant |
| rxd_o | output | 1 | Receive data, 0 = dominant or wake |
| tmo_flag_o | output | 1 | Dominant time-out has released the driver |

## Verification
The failures to expect are an arm flag or time-out flag in the wrong state, or an off-by-one in a run counter. An arm or flag fault shows up at the driver outputs within two or three cycles of the next transmit edge or mode change. A timer that stops one cycle early or late changes the measured length of the dominant stretch by one cycle. A wake counter error changes the number of low cycles seen on `rxd_o` for pulses just below, at and just above the threshold. The bench therefore counts these lengths exactly, rather than only checking levels.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  // Dominant time-out length in clock cycles.
  function automatic int unsigned tmo_cycles(int unsigned cyc_per_us, int unsigned tmo_us);
    return cyc_per_us * tmo_us;
  endfunction

  // Counter width able to hold the value lim.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/bxc_sync.sv
module bxc_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST_VAL[i]}};
      else        st <= {st[0], d[i]};
    end
    assign q[i] = st[1];
  end
endmodule

// File: rtl/bxc_tx_guard.sv
module bxc_tx_guard #(
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s,
  input  logic stby_s,
  output logic drv_en,
  output logic drv_dom,
  output logic tmo_flag,
  output logic tx_rise
);
  localparam int unsigned CW = bxc_pkg::cnt_width(TMO_CYC);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic          txd_q;
  logic          armed;
  logic          tmo;
  logic [CW-1:0] cnt;

  assign tx_rise  = txd_s & ~txd_q;
  assign drv_en   = ~stby_s & armed & ~tmo;
  assign drv_dom  = drv_en & ~txd_s;
  assign tmo_flag = tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
      armed <= 1'b0;
      tmo   <= 1'b0;
      cnt   <= '0;
    end else begin
      txd_q <= txd_s;
      // arm only after transmit has been seen high in normal mode
      if (stby_s)     armed <= 1'b0;
      else if (txd_s) armed <= 1'b1;
      // time-out is cleared only by a transmit rising edge
      if (tx_rise)                    tmo <= 1'b0;
      else if (drv_dom && cnt == LAST) tmo <= 1'b1;
      cnt <= drv_dom ? cnt + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/bxc_wake_filter.sv
module bxc_wake_filter #(
  parameter int unsigned WAKE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_s,
  output logic wake_hit
);
  localparam int unsigned RW = bxc_pkg::cnt_width(WAKE_CYC);
  localparam logic [RW-1:0] SAT = RW'(WAKE_CYC);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (bus_s) run <= (run == SAT) ? run : run + 1'b1;
    else            run <= '0;
  end

  assign wake_hit = (run == SAT);
endmodule

// File: rtl/bxc_ctrl.sv
module bxc_ctrl #(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned TMO_US     = 450,
  parameter int unsigned WAKE_CYC   = 2 * CYC_PER_US
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic stby_in,
  input  logic bus_dom_in,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic rxd_o,
  output logic tmo_flag_o
);
  localparam int unsigned TMO_CYC = bxc_pkg::tmo_cycles(CYC_PER_US, TMO_US);

  logic [2:0] raw_in, syn_in;
  logic txd_s, stby_s, bus_s;
  logic tx_rise, wake_hit;

  assign raw_in = {bus_dom_in, stby_in, txd_in};

  // reset values: bus recessive, standby, transmit idle high
  bxc_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign txd_s  = syn_in[0];
  assign stby_s = syn_in[1];
  assign bus_s  = syn_in[2];

  bxc_tx_guard #(.TMO_CYC(TMO_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .txd_s(txd_s), .stby_s(stby_s),
    .drv_en(drv_en_o), .drv_dom(drv_dom_o), .tmo_flag(tmo_flag_o),
    .tx_rise(tx_rise)
  );

  bxc_wake_filter #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .wake_hit(wake_hit)
  );

  assign rxd_o = stby_s ? ~wake_hit : ~bus_s;
endmodule

// File: rtl/bxc_ctrl_chk.sv
module bxc_ctrl_chk #(
  parameter int unsigned CYC_PER_US = 250,
  parameter int unsigned TMO_US     = 450,
  parameter int unsigned WAKE_CYC   = 500
) (
  input logic clk,
  input logic rst_n,
  input logic stby_s,
  input logic bus_s,
  input logic tx_rise,
  input logic drv_en_o,
  input logic drv_dom_o,
  input logic rxd_o,
  input logic tmo_flag_o
);
  localparam int unsigned TMO_CYC = CYC_PER_US * TMO_US;
  localparam int unsigned DW = bxc_pkg::cnt_width(TMO_CYC + 1);
  localparam int unsigned BW = bxc_pkg::cnt_width(WAKE_CYC);

  logic [DW-1:0] dom_run;
  logic [BW-1:0] bus_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_run <= '0;
      bus_run <= '0;
    end else begin
      dom_run <= !drv_dom_o ? '0 : (dom_run == DW'(TMO_CYC + 1)) ? dom_run : dom_run + 1'b1;
      bus_run <= !bus_s ? '0 : (bus_run == BW'(WAKE_CYC)) ? bus_run : bus_run + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (!drv_en_o && rxd_o && !tmo_flag_o));

  // R4
  stby_release_chk: assert property (@(posedge clk) disable iff (!rst_n) stby_s |-> (!drv_en_o && !drv_dom_o));

  // R5
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) (!stby_s && $past(stby_s)) |-> !drv_en_o);

  // R6
  dom_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) drv_dom_o |-> (int'(dom_run) < int'(TMO_CYC)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (tmo_flag_o && !tx_rise) |=> tmo_flag_o);

  // R7
  flag_release_chk: assert property (@(posedge clk) disable iff (!rst_n) tmo_flag_o |-> !drv_en_o);

  // R8
  rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) !stby_s |-> (rxd_o == !bus_s));

  // R9
  wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (stby_s && int'(bus_run) < int'(WAKE_CYC)) |-> rxd_o);
endmodule

bind bxc_ctrl bxc_ctrl_chk #(
  .CYC_PER_US(CYC_PER_US), .TMO_US(TMO_US), .WAKE_CYC(WAKE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stby_s(stby_s), .bus_s(bus_s), .tx_rise(tx_rise),
  .drv_en_o(drv_en_o), .drv_dom_o(drv_dom_o), .rxd_o(rxd_o), .tmo_flag_o(tmo_flag_o)
);

// File: tb/bxc_ctrl_test.sv
`timescale 1ns/1ps
module bxc_ctrl_test;
  localparam int CPU  = 4;
  localparam int TUS  = 45;
  localparam int WK   = 8;
  localparam int TCYC = CPU * TUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b1, stby_in = 1'b1, bus_dom_in = 1'b0;
  logic drv_en_o, drv_dom_o, rxd_o, tmo_flag_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bxc_ctrl #(.CYC_PER_US(CPU), .TMO_US(TUS), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .stby_in(stby_in),
    .bus_dom_in(bus_dom_in), .drv_en_o(drv_en_o), .drv_dom_o(drv_dom_o),
    .rxd_o(rxd_o), .tmo_flag_o(tmo_flag_o)
  );

  function automatic int exp_dom(int len);
    return (len < TCYC) ? len : TCYC;
  endfunction

  function automatic int exp_wake(int p);
    return (p >= WK) ? p - WK + 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tx_pulse(int len);
    int domc = 0;
    txd_in = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (drv_dom_o) domc++;
    end
    if (len >= TCYC + 2) begin
      chk("R6 flag after time-out", tmo_flag_o, 1);
      chk("R7 released while flagged", drv_en_o, 0);
    end
    txd_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (drv_dom_o) domc++;
    end
    chk((len > TCYC) ? "R6 dominant length capped" : "R2 dominant length", domc, exp_dom(len));
    chk("R7 flag cleared by rising edge", tmo_flag_o, 0);
    chk("R3 recessive with txd high", {drv_en_o, drv_dom_o}, 2'b10);
  endtask

  task automatic bus_pulse(int p);
    int lowc = 0;
    int en_seen = 0;
    bus_dom_in = 1'b1;
    for (int i = 0; i < p + 6; i++) begin
      if (i == p) bus_dom_in = 1'b0;
      txd_in = 1'($urandom_range(0, 1));
      @(negedge clk);
      if (!rxd_o) lowc++;
      if (drv_en_o) en_seen++;
    end
    chk("R9 wake low cycles", lowc, exp_wake(p));
    chk("R4 driver released in standby", en_seen, 0);
  endtask

  initial begin
    int seed_tmp;
    seed_tmp = $urandom(32'd4711);
    idle(5);
    chk("R1 reset outputs", {drv_en_o, drv_dom_o, rxd_o, tmo_flag_o}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {drv_en_o, drv_dom_o, rxd_o, tmo_flag_o}, 4'b0010);

    stby_in = 1'b0;
    idle(4);
    chk("R3 normal idle", {drv_en_o, drv_dom_o}, 2'b10);

    txd_in = 1'b0;
    idle(2);
    chk("R2 dominant after two cycles", {drv_en_o, drv_dom_o}, 2'b11);
    txd_in = 1'b1;
    idle(4);

    stby_in = 1'b1;
    idle(4);
    chk("R4 standby releases", drv_en_o, 0);
    txd_in = 1'b0;
    idle(4);
    chk("R4 txd low ignored in standby", {drv_en_o, drv_dom_o}, 2'b00);
    stby_in = 1'b0;
    idle(10);
    chk("R5 stuck-low txd after mode exit", {drv_en_o, drv_dom_o}, 2'b00);
    txd_in = 1'b1;
    idle(4);
    chk("R5 armed after txd high", {drv_en_o, drv_dom_o}, 2'b10);

    tx_pulse(1);
    tx_pulse(TCYC - 1);
    tx_pulse(TCYC);
    tx_pulse(TCYC + 1);
    tx_pulse(TCYC + 5);
    tx_pulse(3);
    for (int k = 0; k < 10; k++) begin
      tx_pulse($urandom_range(1, 60));
      idle($urandom_range(3, 6));
    end

    begin
      logic h1 = 1'b0, h2 = 1'b0;
      bus_dom_in = 1'b0;
      idle(3);
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (i >= 2) chk("R8 normal receive follows bus", rxd_o, !h2);
        h2 = h1;
        bus_dom_in = 1'($urandom_range(0, 1));
        h1 = bus_dom_in;
      end
      bus_dom_in = 1'b0;
    end

    stby_in = 1'b1;
    idle(4);
    bus_pulse(2);
    bus_pulse(WK - 1);
    bus_pulse(WK);
    bus_pulse(WK + 1);
    bus_pulse(21);
    for (int k = 0; k < 8; k++) bus_pulse($urandom_range(1, 30));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule